// File: doc/BRIEF.md
# Sixteen-Channel Scanned Timer Table

The block provides sixteen periodic timers that software programs through one 32-bit command word. The timers do not run as sixteen parallel counters. Each timer's down-count, reload period, enable flag and mode flag sit in a small table. When a tick strobe arrives, one sequencer starts at timer 0 and updates the table entries one at a time, ending at timer 15. The walk happens on every tick, whether or not any timer is enabled. When an enabled timer runs out, its bit in the event vector pulses for one cycle. A restart timer then reloads its period. A one-shot timer disables itself.

A free-running tick counter advances each time a walk actually services the last entry. A busy input stands for scan slots taken by other work: while it is high the sequencer holds its place. If a new tick arrives before the walk has reached timer 15, the walk starts over at timer 0 and that interval is not counted. Commands may arrive at any time. A command takes the cycle it arrives in and the sequencer waits that cycle, so the command lands between two entry visits.

Top module: `scan_timer_table`

## Requirements
- R1: Command word, numbered big-endian with bit 0 as the MSB (word[31]). Bit 0 is enable, bit 1 (word[30]) is restart, bits 12–15 (word[19:16]) are the timer number, and bits 16–31 (word[15:0]) are the period. A write with enable=1 loads the count and period of the selected timer, copies restart into its mode bit and sets its valid bit. Only a command changes a mode bit.
- R2: A write with enable=0 clears the selected timer's valid bit, and that timer produces no further events.
- R3: A one-shot timer (mode 0) loaded with period P pulses its event bit once, during the walk of the P-th tick after loading, and its valid bit clears at the same time.
- R4: A restart timer (mode 1) with period P pulses once every P ticks and stays valid.
- R5: The tick counter (reset 0) increases by exactly one for each walk that services timer 15. This holds even with no timer enabled.
- R6: While busy is high the walk does not advance. If the next tick arrives before timer 15 is serviced, the tick counter does not increase for that interval. A stalled walk resumes where it stopped once busy falls.
- R7: Each event bit is high for a single cycle, and only for a timer that was valid.
- R8: Bits 2–11 of the command word (word[29:20]) have no effect. They read back as zero on the command readback port, which holds the last written word.
- R9: A command issued during a walk is applied between entry visits. An entry disabled before the walk reaches it produces no event, and the walk still completes.
- R10: A period of 0 means 65536 ticks: the timer does not expire on early ticks.
- R11: Entries are visited in ascending order from timer 0, so a walk cut short by a new tick has already serviced the low-numbered timers and not timer 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle tick strobe; starts a walk at timer 0 |
| busy_i | input | 1 | Scan slot lost to other work; walk holds its place |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_word_i | input | 32 | Command word (big-endian field layout, R1) |
| cmd_rd_o | output | 32 | Last written command, reserved bits zero |
| expire_o | output | 16 | One-cycle event pulse per timer |
| valid_o | output | 16 | Per-timer enable bits |
| mode_o | output | 16 | Per-timer mode bits (1 = restart) |
| tick_cnt_o | output | 32 | Completed-walk tick counter |

## Verification
The timers are driven in four settings: a one-shot and a restart timer on their own, several timers with different periods at once, a walk stalled by busy, and a walk cut short by an early tick. Comparing the one-shot and restart runs separates the reload path from the self-disable path. Running several timers at once shows that each entry is counted separately within a shared walk. The stalled and cut-short walks separate "tick received" from "timer 15 serviced" in the tick counter, and the cut-short walk also shows the visit order. One command is issued in the middle of a walk to show that it lands between visits.

// File: rtl/sttab_pkg.sv
package sttab_pkg;
  localparam int CMD_W = 32;
  localparam int TN_W  = 4;
  localparam int TP_W  = 16;
  localparam int RSV_W = CMD_W - 2 - TN_W - TP_W;

  // Field layout, MSB first: enable, restart, reserved, timer number, period
  typedef struct packed {
    logic             en;
    logic             restart;
    logic [RSV_W-1:0] rsvd;
    logic [TN_W-1:0]  tn;
    logic [TP_W-1:0]  tp;
  } tmr_cmd_t;

  // One decrement of a down-count; 0 wraps to all-ones, giving 65536 for TP=0
  function automatic logic [TP_W-1:0] count_step(input logic [TP_W-1:0] c);
    return c - TP_W'(1);
  endfunction

  // Count reaches zero on this visit
  function automatic logic hits_zero(input logic [TP_W-1:0] c);
    return c == TP_W'(1);
  endfunction

  function automatic logic [CMD_W-1:0] clear_reserved(input tmr_cmd_t w);
    tmr_cmd_t m;
    m      = w;
    m.rsvd = '0;
    return m;
  endfunction
endpackage

// File: rtl/sttab_cmd_decode.sv
module sttab_cmd_decode #(
  parameter int NUM_TMR = 16
) (
  input  logic                              cmd_we,
  input  logic [sttab_pkg::CMD_W-1:0]       cmd_word,
  output logic [NUM_TMR-1:0]                cmd_hit,
  output logic                              cmd_en,
  output logic                              cmd_restart,
  output logic [sttab_pkg::TP_W-1:0]        cmd_tp
);
  import sttab_pkg::*;
  tmr_cmd_t w;
  assign w           = tmr_cmd_t'(cmd_word);
  assign cmd_en      = w.en;
  assign cmd_restart = w.restart;
  assign cmd_tp      = w.tp;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_sel
    assign cmd_hit[i] = cmd_we && (w.tn == TN_W'(i));
  end
endmodule

// File: rtl/sttab_scanner.sv
module sttab_scanner #(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 32,
  localparam int PTR_W  = $clog2(NUM_TMR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             busy_i,
  input  logic             cmd_we_i,
  output logic             visit_en,
  output logic             last_visit,
  output logic [PTR_W-1:0] scan_ptr,
  output logic [CNT_W-1:0] tick_cnt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_TMR - 1);

  logic active_q;

  assign visit_en   = active_q && !busy_i && !cmd_we_i;
  assign last_visit = visit_en && (scan_ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      scan_ptr <= '0;
    end else if (tick_i) begin
      active_q <= 1'b1;
      scan_ptr <= '0;
    end else if (visit_en) begin
      if (scan_ptr == LAST) active_q <= 1'b0;
      else                  scan_ptr <= scan_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          tick_cnt <= '0;
    else if (last_visit) tick_cnt <= tick_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sttab_entries.sv
module sttab_entries #(
  parameter int NUM_TMR = 16,
  localparam int PTR_W  = $clog2(NUM_TMR),
  localparam int TP_W   = sttab_pkg::TP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] cmd_hit,
  input  logic               cmd_en,
  input  logic               cmd_restart,
  input  logic [TP_W-1:0]    cmd_tp,
  input  logic               visit_en,
  input  logic [PTR_W-1:0]   scan_ptr,
  output logic [NUM_TMR-1:0] expire,
  output logic [NUM_TMR-1:0] valid,
  output logic [NUM_TMR-1:0] mode
);
  import sttab_pkg::*;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ent
    logic [TP_W-1:0] cnt_q;
    logic [TP_W-1:0] per_q;
    logic            here;
    assign here = visit_en && (scan_ptr == PTR_W'(i)) && valid[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q     <= '0;
        per_q     <= '0;
        valid[i]  <= 1'b0;
        mode[i]   <= 1'b0;
        expire[i] <= 1'b0;
      end else begin
        expire[i] <= 1'b0;
        if (cmd_hit[i]) begin
          if (cmd_en) begin
            cnt_q    <= cmd_tp;
            per_q    <= cmd_tp;
            mode[i]  <= cmd_restart;
            valid[i] <= 1'b1;
          end else begin
            valid[i] <= 1'b0;
          end
        end else if (here) begin
          if (hits_zero(cnt_q)) begin
            expire[i] <= 1'b1;
            if (mode[i]) cnt_q    <= per_q;
            else         valid[i] <= 1'b0;
          end else begin
            cnt_q <= count_step(cnt_q);
          end
        end
      end
    end
  end
endmodule

// File: rtl/scan_timer_table.sv
module scan_timer_table #(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 32,
  localparam int PTR_W  = $clog2(NUM_TMR),
  localparam int CMD_W  = sttab_pkg::CMD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               busy_i,
  input  logic               cmd_we_i,
  input  logic [CMD_W-1:0]   cmd_word_i,
  output logic [CMD_W-1:0]   cmd_rd_o,
  output logic [NUM_TMR-1:0] expire_o,
  output logic [NUM_TMR-1:0] valid_o,
  output logic [NUM_TMR-1:0] mode_o,
  output logic [CNT_W-1:0]   tick_cnt_o
);
  import sttab_pkg::*;

  logic [NUM_TMR-1:0] cmd_hit;
  logic               cmd_en;
  logic               cmd_restart;
  logic [TP_W-1:0]    cmd_tp;
  logic               visit_en;
  logic               last_visit;
  logic [PTR_W-1:0]   scan_ptr;

  sttab_cmd_decode #(.NUM_TMR(NUM_TMR)) u_dec (
    .cmd_we(cmd_we_i), .cmd_word(cmd_word_i), .cmd_hit(cmd_hit),
    .cmd_en(cmd_en), .cmd_restart(cmd_restart), .cmd_tp(cmd_tp)
  );

  sttab_scanner #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
    .cmd_we_i(cmd_we_i), .visit_en(visit_en), .last_visit(last_visit),
    .scan_ptr(scan_ptr), .tick_cnt(tick_cnt_o)
  );

  sttab_entries #(.NUM_TMR(NUM_TMR)) u_ent (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .cmd_en(cmd_en),
    .cmd_restart(cmd_restart), .cmd_tp(cmd_tp), .visit_en(visit_en),
    .scan_ptr(scan_ptr), .expire(expire_o), .valid(valid_o), .mode(mode_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        cmd_rd_o <= '0;
    else if (cmd_we_i) cmd_rd_o <= clear_reserved(tmr_cmd_t'(cmd_word_i));
  end
endmodule

// File: rtl/sttab_chk.sv
module sttab_chk #(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 32,
  localparam int PTR_W  = $clog2(NUM_TMR)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               busy_i,
  input logic               cmd_we_i,
  input logic [31:0]        cmd_rd_o,
  input logic [NUM_TMR-1:0] expire_o,
  input logic [NUM_TMR-1:0] valid_o,
  input logic [NUM_TMR-1:0] mode_o,
  input logic [CNT_W-1:0]   tick_cnt_o,
  input logic               last_visit,
  input logic [PTR_W-1:0]   scan_ptr
);
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o != '0) |=> ((expire_o & $past(expire_o)) == '0));
  // R7
  pulse_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((expire_o & ~$past(valid_o)) == '0));
  // R3
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o & ~mode_o & valid_o) == '0);
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_visit |=> (tick_cnt_o == $past(tick_cnt_o) + CNT_W'(1)));
  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_visit |=> $stable(tick_cnt_o));
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !tick_i) |=> $stable(scan_ptr));
  // R1
  mode_cmd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we_i |=> $stable(mode_o));
  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd_o[29:20] == '0);
endmodule

bind scan_timer_table sttab_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
  .cmd_we_i(cmd_we_i), .cmd_rd_o(cmd_rd_o), .expire_o(expire_o),
  .valid_o(valid_o), .mode_o(mode_o), .tick_cnt_o(tick_cnt_o),
  .last_visit(last_visit), .scan_ptr(scan_ptr)
);

// File: tb/sim_scan_timer_table.sv
module sim_scan_timer_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        busy_i = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic [31:0] cmd_rd_o;
  logic [15:0] expire_o, valid_o, mode_o;
  logic [31:0] tick_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int pcnt [16];
  int base [16];

  always #4 clk = ~clk;

  scan_timer_table u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
    .cmd_we_i(cmd_we_i), .cmd_word_i(cmd_word_i), .cmd_rd_o(cmd_rd_o),
    .expire_o(expire_o), .valid_o(valid_o), .mode_o(mode_o),
    .tick_cnt_o(tick_cnt_o)
  );

  initial for (int i = 0; i < 16; i++) pcnt[i] = 0;
  always @(negedge clk)
    if (rst_n) for (int i = 0; i < 16; i++) if (expire_o[i]) pcnt[i] = pcnt[i] + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic v, input logic r, input logic [3:0] tn,
                                     input logic [15:0] tp, input logic [9:0] rs);
    return {v, r, rs, tn, tp};
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(input logic [31:0] w);
    @(negedge clk); cmd_we_i = 1'b1; cmd_word_i = w;
    @(negedge clk); cmd_we_i = 1'b0; cmd_word_i = '0;
  endtask

  task automatic tick_full();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    wait_n(20);
  endtask

  task automatic snap();
    for (int i = 0; i < 16; i++) base[i] = pcnt[i];
  endtask

  function automatic int got(input int i);
    return pcnt[i] - base[i];
  endfunction

  task automatic t_reset();
    chk("R5 reset tick_cnt", tick_cnt_o, 0);
    chk("R7 reset expire", {16'h0, expire_o}, 0);
    chk("R1 reset valid", {16'h0, valid_o}, 0);
    chk("R1 reset mode", {16'h0, mode_o}, 0);
  endtask

  task automatic t_idle_ticks();
    logic [31:0] c0;
    c0 = tick_cnt_o;
    tick_full(); tick_full(); tick_full();
    chk("R5 idle walks counted", tick_cnt_o, c0 + 3);
  endtask

  task automatic t_oneshot();
    cmd(mk(1, 0, 4'd2, 16'd3, '0));
    chk("R1 valid set", {31'h0, valid_o[2]}, 1);
    chk("R1 mode oneshot", {31'h0, mode_o[2]}, 0);
    snap();
    tick_full(); tick_full();
    chk("R3 no early pulse", got(2), 0);
    tick_full();
    chk("R3 pulse at P", got(2), 1);
    chk("R3 valid cleared", {31'h0, valid_o[2]}, 0);
    tick_full(); tick_full(); tick_full();
    chk("R3 single pulse", got(2), 1);
  endtask

  task automatic t_restart_multi();
    cmd(mk(1, 1, 4'd7, 16'd2, '0));
    cmd(mk(1, 1, 4'd11, 16'd3, '0));
    chk("R1 mode restart", {30'h0, mode_o[11], mode_o[7]}, 3);
    snap();
    for (int k = 0; k < 6; k++) tick_full();
    chk("R4 period 2 pulses", got(7), 3);
    chk("R4 period 3 pulses", got(11), 2);
    chk("R4 stays valid", {30'h0, valid_o[11], valid_o[7]}, 3);
    chk("R7 other timers quiet", got(6) + got(8), 0);
  endtask

  task automatic t_disable();
    cmd(mk(0, 0, 4'd7, 16'd0, '0));
    chk("R2 valid cleared", {31'h0, valid_o[7]}, 0);
    chk("R2 mode unchanged", {31'h0, mode_o[7]}, 1);
    snap();
    tick_full(); tick_full(); tick_full();
    chk("R2 no pulses", got(7), 0);
    cmd(mk(0, 0, 4'd11, 16'd0, '0));
  endtask

  task automatic t_reserved();
    cmd(mk(1, 0, 4'd4, 16'd1, 10'h3FF));
    chk("R8 readback reserved zero", cmd_rd_o, mk(1, 0, 4'd4, 16'd1, '0));
    chk("R8 timer 4 loaded", {31'h0, valid_o[4]}, 1);
    snap();
    tick_full();
    chk("R8 behaves as clean command", got(4), 1);
  endtask

  task automatic t_zero_period();
    cmd(mk(1, 1, 4'd9, 16'd0, '0));
    snap();
    for (int k = 0; k < 4; k++) tick_full();
    chk("R10 period 0 not early", got(9), 0);
    chk("R10 still valid", {31'h0, valid_o[9]}, 1);
    cmd(mk(0, 0, 4'd9, 16'd0, '0));
  endtask

  task automatic t_stall();
    logic [31:0] c0;
    cmd(mk(1, 1, 4'd15, 16'd1, '0));
    c0 = tick_cnt_o;
    snap();
    @(negedge clk); busy_i = 1'b1;
    tick_full();
    chk("R6 stalled walk not counted", tick_cnt_o, c0);
    chk("R6 stalled entry not serviced", got(15), 0);
    @(negedge clk); busy_i = 1'b0;
    wait_n(20);
    chk("R6 resumed walk counted", tick_cnt_o, c0 + 1);
    chk("R6 resumed walk serviced 15", got(15), 1);
  endtask

  task automatic t_abort();
    logic [31:0] c0;
    cmd(mk(1, 1, 4'd0, 16'd1, '0));
    c0 = tick_cnt_o;
    snap();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    wait_n(5);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    wait_n(20);
    chk("R6 cut-short interval not counted", tick_cnt_o, c0 + 1);
    chk("R11 timer 0 served in both walks", got(0), 2);
    chk("R11 timer 15 served once", got(15), 1);
    cmd(mk(0, 0, 4'd0, 16'd0, '0));
    cmd(mk(0, 0, 4'd15, 16'd0, '0));
  endtask

  task automatic t_mid_scan();
    logic [31:0] c0;
    cmd(mk(1, 1, 4'd3, 16'd1, '0));
    cmd(mk(1, 1, 4'd12, 16'd1, '0));
    c0 = tick_cnt_o;
    snap();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; cmd_we_i = 1'b1; cmd_word_i = mk(0, 0, 4'd3, 16'd0, '0);
    @(negedge clk); cmd_we_i = 1'b0; cmd_word_i = '0;
    wait_n(20);
    chk("R9 entry disabled before visit", got(3), 0);
    chk("R9 later entry serviced", got(12), 1);
    chk("R9 walk completes", tick_cnt_o, c0 + 1);
    cmd(mk(0, 0, 4'd12, 16'd0, '0));
  endtask

  initial begin
    wait_n(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_idle_ticks();
    t_oneshot();
    t_restart_multi();
    t_disable();
    t_reserved();
    t_zero_period();
    t_stall();
    t_abort();
    t_mid_scan();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule